// File: doc/BRIEF.md
# Dual Comparator Control and Status Registers

This block is the digital side of a pair of analog comparators. It keeps one control register for each channel and one shared status register, all behind a plain 32-bit read/write port that is addressed by word. Each control register drives the enable, hysteresis and negative-input select toward the analog macro. It also holds an inversion bit and an interrupt enable. Both of these act inside the block.

The raw comparator decisions arrive as asynchronous bits and pass through a two-flop synchronizer. After that, each bit is optionally inverted and then gated by its channel enable. The result is the channel's processed output. A change of the processed output while the channel stays enabled sets a sticky flag in the status register. Software clears the flag by writing 1 to it. A single interrupt line is the OR of the flags whose interrupt enable is set.

The bus has no data stream and no back-pressure. A write takes effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. Word address 3 reads as zero, and writes to it are dropped.

Top module: `dual_cmp_csr`

## Requirements
- R1: After reset, both control words, the status word, `irq` and all per-channel outputs are 0.
- R2: Channel 0 control sits at word address 0 and channel 1 control at word address 1. In each control word, bit 0 is enable (drives `cmp_en`), bit 1 is interrupt enable, bit 2 is hysteresis (drives `cmp_hyst`), bit 4 is negative-input select (drives `cmp_nsel`, 1 = internal reference) and bit 6 is output inversion. The written value reads back.
- R3: Control bits 3, 5 and 7 to 31 read as 0 whatever is written. Status bits 4 to 31 read as 0. Word address 3 reads as 0.
- R4: The status word is at word address 2. Bit 2 shows channel 0's processed output and bit 3 shows channel 1's. A change on `cmp_raw` reaches these bits after two rising clock edges.
- R5: With inversion set, the processed output is the complement of the synchronized raw bit.
- R6: While a channel is disabled, its processed output reads 0 and its flag is never set. Setting or clearing the enable bit alone does not set the flag.
- R7: While enabled, any change of the processed output, rising or falling, sets that channel's flag (status bit 0 for channel 0, bit 1 for channel 1) three edges after the raw input changes.
- R8: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. Writing to status bits 2 and 3 has no effect.
- R9: When a change event and a clearing write reach the same flag in the same cycle, the flag stays set.
- R10: `irq` is high exactly when at least one channel has its flag set and its interrupt enable bit (control bit 1) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Word address (0, 1 = control; 2 = status) |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cmp_raw | input | 2 | Raw comparator outputs, asynchronous |
| cmp_en | output | 2 | Per-channel enable to the analog macro |
| cmp_hyst | output | 2 | Per-channel hysteresis enable |
| cmp_nsel | output | 2 | Per-channel negative input select, 1 = internal reference |
| irq | output | 1 | Combined interrupt request |

## Verification
A hardware flag set and a software write-1 clear can land on the same flag in the same cycle. The bench provokes this by toggling the raw input of a channel whose flag is already set, then timing a clearing write so that it reaches its edge together with the change event, two edges after the raw change has been synchronized. The flag is judged still set after that edge, and a later lone clearing write is judged to clear it. The bench also combines an enable change with a pending input level, and checks that the processed output moves but no flag is set.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned BIT_EN  = 0;
  localparam int unsigned BIT_IE  = 1;
  localparam int unsigned BIT_HY  = 2;
  localparam int unsigned BIT_NS  = 4;
  localparam int unsigned BIT_INV = 6;

  typedef struct packed {
    logic inv;
    logic nsel;
    logic hyst;
    logic ie;
    logic en;
  } ctl_t;

  function automatic ctl_t ctl_from_word(logic [REG_W-1:0] w);
    ctl_t c;
    c.en   = w[BIT_EN];
    c.ie   = w[BIT_IE];
    c.hyst = w[BIT_HY];
    c.nsel = w[BIT_NS];
    c.inv  = w[BIT_INV];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctl_to_word(ctl_t c);
    logic [REG_W-1:0] w;
    w          = '0;
    w[BIT_EN]  = c.en;
    w[BIT_IE]  = c.ie;
    w[BIT_HY]  = c.hyst;
    w[BIT_NS]  = c.nsel;
    w[BIT_INV] = c.inv;
    return w;
  endfunction
endpackage

// File: rtl/dcmp_sync.sv
module dcmp_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(STAGES); k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < int'(STAGES); k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dcmp_chan.sv
module dcmp_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic inv,
  input  logic ie,
  input  logic s_in,
  input  logic clr,
  output logic co,
  output logic flag,
  output logic req
);
  logic co_q, en_q, flag_q, evt;

  // processed output: inversion first, then gated by enable
  assign co  = en & (s_in ^ inv);
  // a change counts only when enabled in both this and the previous cycle
  assign evt = en & en_q & (co ^ co_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      co_q   <= 1'b0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      co_q <= co;
      en_q <= en;
      if (evt)      flag_q <= 1'b1;  // set beats clear
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;
  assign req  = flag_q & ie;
endmodule

// File: rtl/dual_cmp_csr.sv
module dual_cmp_csr
  import dcmp_pkg::*;
#(
  parameter  int unsigned NCH         = 2,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW          = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [NCH-1:0]   cmp_raw,
  output logic [NCH-1:0]   cmp_en,
  output logic [NCH-1:0]   cmp_hyst,
  output logic [NCH-1:0]   cmp_nsel,
  output logic             irq
);
  localparam logic [AW-1:0] STAT_ADDR = AW'(NCH);

  ctl_t           ctl_q [NCH];
  logic [NCH-1:0] sync_w, co_w, flag_w, req_w, ie_w, clr_w;
  logic           stat_wr;
  logic           unused_wbits;

  assign unused_wbits = ^bus_wdata;
  assign stat_wr      = bus_wr && (bus_addr == STAT_ADDR);

  dcmp_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(sync_w)
  );

  for (genvar i = 0; i < int'(NCH); i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) ctl_q[i] <= '0;
      else if (bus_wr && bus_addr == AW'(i)) ctl_q[i] <= ctl_from_word(bus_wdata);
    end

    assign clr_w[i]    = stat_wr & bus_wdata[i];
    assign cmp_en[i]   = ctl_q[i].en;
    assign cmp_hyst[i] = ctl_q[i].hyst;
    assign cmp_nsel[i] = ctl_q[i].nsel;
    assign ie_w[i]     = ctl_q[i].ie;

    dcmp_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .en(ctl_q[i].en), .inv(ctl_q[i].inv), .ie(ctl_q[i].ie),
      .s_in(sync_w[i]), .clr(clr_w[i]),
      .co(co_w[i]), .flag(flag_w[i]), .req(req_w[i])
    );
  end

  assign irq = |req_w;

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < int'(NCH); i++) begin
      if (bus_addr == AW'(i)) bus_rdata = ctl_to_word(ctl_q[i]);
    end
    if (bus_addr == STAT_ADDR) begin
      bus_rdata[NCH-1:0]     = flag_w;
      bus_rdata[2*NCH-1:NCH] = co_w;
    end
  end
endmodule

// File: rtl/dcmp_csr_checks.sv
module dcmp_csr_checks #(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_wr,
  input logic [NCH-1:0] wr_bits,
  input logic           irq,
  input logic [NCH-1:0] en,
  input logic [NCH-1:0] ie,
  input logic [NCH-1:0] co,
  input logic [NCH-1:0] flag
);
  localparam logic [AW-1:0] STAT_ADDR = AW'(NCH);

  for (genvar i = 0; i < int'(NCH); i++) begin : g_chk
    // R7: a flag rises only after the processed output changed
    p_rise_after_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> ($past(co[i]) != $past(co[i], 2)));

    // R6: a flag rises only if the channel was enabled across the change
    p_rise_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> ($past(en[i]) && $past(en[i], 2)));

    // R8: a flag falls only through a status write carrying a 1 in its bit
    p_fall_by_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |-> $past(bus_wr && bus_addr == STAT_ADDR && wr_bits[i]));
  end

  // R10: the interrupt needs a flagged channel with its interrupt enabled
  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(flag & ie)));
endmodule

bind dual_cmp_csr dcmp_csr_checks #(.NCH(NCH), .AW(AW)) u_checks (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .wr_bits(bus_wdata[NCH-1:0]), .irq(irq), .en(cmp_en), .ie(ie_w),
  .co(co_w), .flag(flag_w)
);

// File: tb/dual_cmp_csr_test.sv
module dual_cmp_csr_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  cmp_raw = '0;
  logic [1:0]  cmp_en, cmp_hyst, cmp_nsel;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_cmp_csr uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_raw(cmp_raw),
    .cmp_en(cmp_en), .cmp_hyst(cmp_hyst), .cmp_nsel(cmp_nsel), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); chk(v, 0, "R1 ctl0");
    rd(2'd1, v); chk(v, 0, "R1 ctl1");
    rd(2'd2, v); chk(v, 0, "R1 status");
    chk({29'd0, irq, 2'd0}, 0, "R1 irq");
    chk({26'd0, cmp_en, cmp_hyst, cmp_nsel}, 0, "R1 outputs");
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(2'd0, 32'h15);
    rd(2'd0, v); chk(v, 32'h15, "R2 ctl0 readback");
    chk({30'd0, cmp_en}, 1, "R2 cmp_en");
    chk({30'd0, cmp_hyst}, 1, "R2 cmp_hyst");
    chk({30'd0, cmp_nsel}, 1, "R2 cmp_nsel");
    wr(2'd1, 32'h10);
    rd(2'd1, v); chk(v, 32'h10, "R2 ctl1 readback");
    chk({30'd0, cmp_nsel}, 3, "R2 cmp_nsel ch1");
    chk({30'd0, cmp_en}, 1, "R2 cmp_en ch1 off");
    wr(2'd0, 0); wr(2'd1, 0);
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk(v, 32'h57, "R3 ctl1 reserved");
    wr(2'd0, 32'hFFFF_FFA8);
    rd(2'd0, v); chk(v, 0, "R3 ctl0 reserved only");
    rd(2'd2, v); chk(v & 32'hFFFF_FFF0, 0, "R3 status reserved");
    rd(2'd3, v); chk(v, 0, "R3 unmapped word");
    wr(2'd1, 0);
    cyc(3);
    rd(2'd2, v); chk(v, 0, "R6 ch1 enable toggle no flag");
  endtask

  task automatic t_sync_invert;
    logic [31:0] v;
    wr(2'd1, 32'h41);
    rd(2'd2, v); chk(v, 32'h8, "R5 inverted low input reads 1");
    cmp_raw[1] = 1'b1;
    cyc(1); rd(2'd2, v); chk(v, 32'h8, "R4 not yet after one edge");
    cyc(1); rd(2'd2, v); chk(v, 32'h0, "R4 R5 visible after two edges");
    cyc(1); rd(2'd2, v); chk(v, 32'h2, "R7 ch1 flag");
    wr(2'd2, 32'h2);
    rd(2'd2, v); chk(v, 0, "R8 ch1 clear");
    wr(2'd1, 0);
  endtask

  task automatic t_flag_edges;
    logic [31:0] v;
    wr(2'd0, 32'h1);
    cyc(3); rd(2'd2, v); chk(v, 0, "R7 quiet input");
    cmp_raw[0] = 1'b1;
    cyc(2); rd(2'd2, v); chk(v, 32'h4, "R4 ch0 output before flag");
    cyc(1); rd(2'd2, v); chk(v, 32'h5, "R7 rising change flag");
    wr(2'd2, 32'h1);
    rd(2'd2, v); chk(v, 32'h4, "R8 clear keeps output");
    cmp_raw[0] = 1'b0;
    cyc(3); rd(2'd2, v); chk(v, 32'h1, "R7 falling change flag");
    wr(2'd2, 32'h1);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    wr(2'd0, 0);
    cmp_raw[0] = 1'b1;
    cyc(4); rd(2'd2, v); chk(v, 0, "R6 disabled output and flag");
    wr(2'd0, 32'h1);
    cyc(3); rd(2'd2, v); chk(v, 32'h4, "R6 enable with high input no flag");
    wr(2'd0, 0);
    cyc(3); rd(2'd2, v); chk(v, 0, "R6 disable no flag");
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(2'd0, 32'h1); wr(2'd1, 32'h1);
    cmp_raw = 2'b00;
    cyc(3); rd(2'd2, v); chk(v, 32'h3, "R7 both flags");
    wr(2'd2, 0);
    rd(2'd2, v); chk(v, 32'h3, "R8 write zero");
    wr(2'd2, 32'hC);
    rd(2'd2, v); chk(v, 32'h3, "R8 output bits write");
    wr(2'd2, 32'h2);
    rd(2'd2, v); chk(v, 32'h1, "R8 clear ch1 only");
    wr(2'd2, 32'h1);
    rd(2'd2, v); chk(v, 0, "R8 clear ch0");
    wr(2'd1, 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    cmp_raw[0] = 1'b1;
    cyc(3); rd(2'd2, v); chk(v, 32'h5, "R7 flag before race");
    cmp_raw[0] = 1'b0;
    cyc(1);
    wr(2'd2, 32'h1);
    rd(2'd2, v); chk(v, 32'h1, "R9 set wins over clear");
    wr(2'd2, 32'h1);
    rd(2'd2, v); chk(v, 0, "R9 later clear works");
  endtask

  task automatic t_irq;
    cmp_raw[0] = 1'b1;
    cyc(3); chk({31'd0, irq}, 0, "R10 ie off");
    wr(2'd0, 32'h3);
    chk({31'd0, irq}, 1, "R10 ch0 irq");
    wr(2'd2, 32'h1);
    chk({31'd0, irq}, 0, "R10 irq drops on clear");
    wr(2'd1, 32'h3);
    cmp_raw[1] = 1'b1;
    cyc(3); chk({31'd0, irq}, 1, "R10 ch1 irq");
    wr(2'd2, 32'h2);
    chk({31'd0, irq}, 0, "R10 ch1 cleared");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL R1 watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_reserved();
    t_sync_invert();
    t_flag_edges();
    t_disabled();
    t_w1c();
    t_set_wins();
    t_irq();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule